// File: doc/BRIEF.md
# LCD Common-Row Scan Generator

This block produces the row-scan timing for a dot-matrix LCD common driver. It moves a single select token through a chain of common outputs, so that exactly one panel row is selected at a time. In master mode an oscillator tick enable drives an internal timing generator. That generator derives the row latch clock, a frame marker, a polarity-alternation signal and two quarter-phase column clocks. The row count per frame is chosen from four duty settings. The token is re-injected at the first row of every frame.

In slave mode the internal timing generator stays idle. The block takes its shift clock and its polarity signal from an external master. The chain then behaves as a plain shift register between its two bidirectional ends. A direction select picks which end feeds the chain and which end receives the bit leaving it. A phase select picks whether shifts happen on the rising or on the falling edge of the row clock. Each bidirectional end is modelled as a separate input, output and output-enable. All inputs are taken as synchronous to `clk`.

Top module: `lcd_row_scan`

## Requirements
- R1: `duty_sel` sets the rows per frame: 0 gives 48, 1 gives 64, 2 gives 96 and 3 gives 128. In master mode, consecutive rising edges of `frame_mark` are rows × 4 quarters apart, with each quarter as defined in R2.
- R2: In master mode, one quarter lasts `QTR_TICKS` asserted `osc_tick` cycles when `freq_sel` is 1, and `QTR_TICKS/2` when `freq_sel` is 0. Cycles without `osc_tick` do not advance the timing.
- R3: A row period has four quarters, numbered 0 to 3. In master mode `row_clk` is high in quarters 0 and 1, `col_clk_a` is low only in quarter 0, and `col_clk_b` is low only in quarter 1, so it lags `col_clk_a` by one quarter.
- R4: In master mode, `frame_mark` is high for exactly one row period. That period begins at the row boundary that opens the first row of a frame.
- R5: In master mode, `alt_pol` inverts once at each frame start and at no other time.
- R6: With `shift_on_rise` = 1 the chain moves on the rising edge of the row clock. With 0 it moves on the falling edge. In master mode, the falling-edge setting loads the new frame token at mid-row of the first row.
- R7: In master mode, the frame token is loaded into the near stage and every other stage is cleared. The token then advances one stage per shift, and no more than one stage is set. The near stage is `com_sel[0]` with the direction moving upward when `scan_up` = 1, and `com_sel[N_COM-1]` with the direction moving downward when `scan_up` = 0.
- R8: In master mode, both end enables are 1. The near end (end1 when `scan_up` = 1, else end2) outputs `frame_mark`. The far end outputs the far stage of the chain.
- R9: In slave mode, the near end's enable is 0 and its input is shifted into the near stage at each selected edge of `ext_shift_clk`. The chain is never cleared, so several tokens can be present at once. The far end's enable is 1 and it outputs the far stage.
- R10: In slave mode, `row_clk` and `alt_pol` follow `ext_shift_clk` and `ext_alt` one cycle later. `frame_mark`, `col_clk_a` and `col_clk_b` are held low.
- R11: Synchronous reset empties the chain and drives `frame_mark` and `alt_pol` low. It puts the timing at the start of quarter 0 and parks the row counter so that the first row boundary after reset opens a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | Oscillator tick enable |
| master_mode | input | 1 | 1 = generate timing internally, 0 = follow external master |
| duty_sel | input | 2 | Rows-per-frame select |
| freq_sel | input | 1 | Oscillator rate select (1 = fast, more ticks per quarter) |
| scan_up | input | 1 | Chain direction select |
| shift_on_rise | input | 1 | Shift on rising (1) or falling (0) row-clock edge |
| ext_shift_clk | input | 1 | Shift clock from external master (slave mode) |
| ext_alt | input | 1 | Polarity signal from external master (slave mode) |
| end1_in | input | 1 | Chain end 1, input side |
| end1_out | output | 1 | Chain end 1, output side |
| end1_oe | output | 1 | Chain end 1, output enable |
| end2_in | input | 1 | Chain end 2, input side |
| end2_out | output | 1 | Chain end 2, output side |
| end2_oe | output | 1 | Chain end 2, output enable |
| row_clk | output | 1 | Row latch clock |
| frame_mark | output | 1 | Frame start marker |
| alt_pol | output | 1 | Drive polarity alternation |
| col_clk_a | output | 1 | Column clock, phase A |
| col_clk_b | output | 1 | Column clock, phase B |
| com_sel | output | N_COM | Common-row select vector |

## Verification
The bench builds the block with `QTR_TICKS` = 2 and `N_COM` = 64. With these values the slow rate runs one tick per quarter and the fast rate runs two. A 128-row frame therefore fits in about a thousand cycles, so the bench can cover all four duty settings, both rates and both shift edges over several whole frames. A duty of 48 rows brings into reach the case where a token still sits mid-chain when the next frame reloads it. Duties above 64 bring into reach the case where the token leaves through the far end and the chain stays empty until the frame wraps. Ticks gated to every other cycle show that the timing advances only on enabled cycles.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int MAX_ROWS = 128;
    localparam int ROW_W    = $clog2(MAX_ROWS);

    typedef enum logic [1:0] {
        QTR_0 = 2'd0,
        QTR_1 = 2'd1,
        QTR_2 = 2'd2,
        QTR_3 = 2'd3
    } quarter_e;

    function automatic int unsigned rows_of(input logic [1:0] sel);
        unique case (sel)
            2'd0:    rows_of = 48;
            2'd1:    rows_of = 64;
            2'd2:    rows_of = 96;
            default: rows_of = 128;
        endcase
    endfunction

endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
    import lcd_scan_pkg::*;
#(
    parameter int QTR_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  logic       tick_i,
    input  logic       fsel_i,
    input  logic [1:0] duty_i,
    input  logic       ext_alt_i,
    output logic       row_clk_o,
    output logic       col_a_o,
    output logic       col_b_o,
    output logic       frame_o,
    output logic       alt_o,
    output logic       rise_o,
    output logic       fall_o,
    output logic       wrap_o
);

    localparam int TW     = $clog2(QTR_TICKS) + 1;
    localparam int QLO    = (QTR_TICKS / 2 > 0) ? QTR_TICKS / 2 : 1;

    typedef struct packed {
        logic [TW-1:0]    tick;
        quarter_e         qtr;
        logic [ROW_W-1:0] row;
        logic             frm;
        logic             alt;
    } tstate_t;

    tstate_t st_d, st_q;
    logic [TW-1:0]    qlen;
    logic [ROW_W-1:0] last_row;

    always_comb begin
        st_d     = st_q;
        rise_o   = 1'b0;
        fall_o   = 1'b0;
        wrap_o   = 1'b0;
        qlen     = fsel_i ? TW'(QTR_TICKS) : TW'(QLO);
        last_row = ROW_W'(rows_of(duty_i) - 1);
        if (!run_i) begin
            st_d.tick = '0;
            st_d.qtr  = QTR_0;
            st_d.row  = '1;
            st_d.frm  = 1'b0;
            st_d.alt  = ext_alt_i;
        end else begin
            if (tick_i) begin
                if (st_q.tick >= qlen - TW'(1)) begin
                    st_d.tick = '0;
                    st_d.qtr  = quarter_e'(2'(st_q.qtr) + 2'd1);
                    rise_o    = (st_q.qtr == QTR_3);
                    fall_o    = (st_q.qtr == QTR_1);
                end else begin
                    st_d.tick = st_q.tick + TW'(1);
                end
            end
            if (rise_o) begin
                wrap_o    = (st_q.row >= last_row);
                st_d.row  = wrap_o ? '0 : st_q.row + ROW_W'(1);
                st_d.frm  = wrap_o;
                if (wrap_o) begin
                    st_d.alt = ~st_q.alt;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.tick <= '0;
            st_q.qtr  <= QTR_0;
            st_q.row  <= '1;
            st_q.frm  <= 1'b0;
            st_q.alt  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_clk_o = run_i & ((st_q.qtr == QTR_0) | (st_q.qtr == QTR_1));
    assign col_a_o   = run_i & (st_q.qtr != QTR_0);
    assign col_b_o   = run_i & (st_q.qtr != QTR_1);
    assign frame_o   = st_q.frm;
    assign alt_o     = st_q.alt;

    // R3
    col_a_fall_chk: assert property (@(posedge clk) disable iff (rst || !run_i)
        $fell(col_a_o) |-> $rose(row_clk_o));

    // R4
    frame_on_row_edge_chk: assert property (@(posedge clk) disable iff (rst || !run_i)
        $rose(frame_o) |-> $rose(row_clk_o));

    // R5
    alt_at_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && $past(run_i) && (alt_o != $past(alt_o))) |-> $rose(frame_o));

endmodule

// File: rtl/lcd_edge_pick.sv
module lcd_edge_pick (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    input  logic on_rise_i,
    output logic lvl_o,
    output logic edge_o
);

    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d  = lvl_i;
        edge_o = on_rise_i ? (lvl_i & ~lvl_q) : (~lvl_i & lvl_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign lvl_o = lvl_q;

endmodule

// File: rtl/lcd_com_chain.sv
module lcd_com_chain #(
    parameter int N_COM = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_i,
    input  logic             load_i,
    input  logic             din_i,
    input  logic             up_i,
    output logic [N_COM-1:0] com_o
);

    logic [N_COM-1:0] com_d, com_q;
    logic [N_COM-1:0] from_lo, from_hi, near_vec;

    for (genvar k = 0; k < N_COM; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign from_lo[k] = din_i;
        end else begin : g_mid_lo
            assign from_lo[k] = com_q[k-1];
        end
        if (k == N_COM - 1) begin : g_last
            assign from_hi[k] = din_i;
        end else begin : g_mid_hi
            assign from_hi[k] = com_q[k+1];
        end
        assign near_vec[k] = up_i ? (k == 0) : (k == N_COM - 1);
    end

    always_comb begin
        com_d = com_q;
        if (load_i) begin
            com_d = near_vec;
        end else if (shift_i) begin
            com_d = up_i ? from_lo : from_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            com_q <= '0;
        end else begin
            com_q <= com_d;
        end
    end

    assign com_o = com_q;

    // R7
    single_token_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> $onehot(com_o));

endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
    import lcd_scan_pkg::*;
#(
    parameter int QTR_TICKS = 2,
    parameter int N_COM     = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_tick,
    input  logic             master_mode,
    input  logic [1:0]       duty_sel,
    input  logic             freq_sel,
    input  logic             scan_up,
    input  logic             shift_on_rise,
    input  logic             ext_shift_clk,
    input  logic             ext_alt,
    input  logic             end1_in,
    output logic             end1_out,
    output logic             end1_oe,
    input  logic             end2_in,
    output logic             end2_out,
    output logic             end2_oe,
    output logic             row_clk,
    output logic             frame_mark,
    output logic             alt_pol,
    output logic             col_clk_a,
    output logic             col_clk_b,
    output logic [N_COM-1:0] com_sel
);

    logic rise_ev, fall_ev, wrap_ev, t_row_clk;
    logic slv_lvl, slv_edge;
    logic chain_shift, chain_load, chain_din;
    logic near_bit, far_bit, near_out;

    lcd_scan_timer #(.QTR_TICKS(QTR_TICKS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (master_mode),
        .tick_i    (osc_tick),
        .fsel_i    (freq_sel),
        .duty_i    (duty_sel),
        .ext_alt_i (ext_alt),
        .row_clk_o (t_row_clk),
        .col_a_o   (col_clk_a),
        .col_b_o   (col_clk_b),
        .frame_o   (frame_mark),
        .alt_o     (alt_pol),
        .rise_o    (rise_ev),
        .fall_o    (fall_ev),
        .wrap_o    (wrap_ev)
    );

    lcd_edge_pick u_edge (
        .clk       (clk),
        .rst       (rst),
        .lvl_i     (ext_shift_clk),
        .on_rise_i (shift_on_rise),
        .lvl_o     (slv_lvl),
        .edge_o    (slv_edge)
    );

    always_comb begin
        if (master_mode) begin
            chain_shift = shift_on_rise ? rise_ev : fall_ev;
            chain_load  = shift_on_rise ? wrap_ev : (fall_ev & frame_mark);
            chain_din   = 1'b0;
        end else begin
            chain_shift = slv_edge;
            chain_load  = 1'b0;
            chain_din   = scan_up ? end1_in : end2_in;
        end
    end

    lcd_com_chain #(.N_COM(N_COM)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .shift_i (chain_shift),
        .load_i  (chain_load),
        .din_i   (chain_din),
        .up_i    (scan_up),
        .com_o   (com_sel)
    );

    assign far_bit  = scan_up ? com_sel[N_COM-1] : com_sel[0];
    assign near_bit = scan_up ? com_sel[0] : com_sel[N_COM-1];
    assign near_out = master_mode & frame_mark;

    assign end1_out = scan_up ? near_out : far_bit;
    assign end1_oe  = scan_up ? master_mode : 1'b1;
    assign end2_out = scan_up ? far_bit : near_out;
    assign end2_oe  = scan_up ? 1'b1 : master_mode;
    assign row_clk  = master_mode ? t_row_clk : slv_lvl;

    // R9
    slave_shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        (!master_mode && slv_edge && chain_din) |=>
            (!$stable(scan_up) || master_mode || near_bit));

endmodule

// File: tb/test_lcd_row_scan.sv
module test_lcd_row_scan;

    localparam int CLK_PERIOD = 10;
    localparam int QT         = 2;
    localparam int N          = 64;

    logic clk = 1'b0;
    logic rst, osc_tick, master_mode, freq_sel, scan_up, shift_on_rise;
    logic [1:0] duty_sel;
    logic ext_shift_clk, ext_alt, end1_in, end2_in;
    logic end1_out, end1_oe, end2_out, end2_oe;
    logic row_clk, frame_mark, alt_pol, col_clk_a, col_clk_b;
    logic [N-1:0] com_sel;

    lcd_row_scan #(.QTR_TICKS(QT), .N_COM(N)) i_lcd_row_scan (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .master_mode(master_mode),
        .duty_sel(duty_sel), .freq_sel(freq_sel), .scan_up(scan_up),
        .shift_on_rise(shift_on_rise), .ext_shift_clk(ext_shift_clk), .ext_alt(ext_alt),
        .end1_in(end1_in), .end1_out(end1_out), .end1_oe(end1_oe),
        .end2_in(end2_in), .end2_out(end2_out), .end2_oe(end2_oe),
        .row_clk(row_clk), .frame_mark(frame_mark), .alt_pol(alt_pol),
        .col_clk_a(col_clk_a), .col_clk_b(col_clk_b), .com_sel(com_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0, tick_div = 1;
    bit done = 1'b0;
    int e_tck, e_qtr, e_row, e_frm, e_alt, e_clq;
    int toks[$];
    int last_frm_rise, last_cl_rise;
    logic prev_frm, prev_cl;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        e_tck = 0; e_qtr = 0; e_row = 127; e_frm = 0; e_alt = 0; e_clq = 0;
        toks = {};
    endtask

    task automatic advance_toks();
        int nt[$];
        foreach (toks[i]) if (toks[i] + 1 < N) nt.push_back(toks[i] + 1);
        toks = nt;
    endtask

    int rows_tab[4] = '{48, 64, 96, 128};

    task automatic model_step();
        int qlen;
        bit rise, fall, wrap, sh, inj, edg, old_frm;
        if (rst) begin
            model_reset();
            return;
        end
        if (master_mode) begin
            qlen = freq_sel ? QT : QT / 2;
            rise = 0; fall = 0; wrap = 0;
            old_frm = (e_frm != 0);
            if (osc_tick) begin
                if (e_tck >= qlen - 1) begin
                    e_tck = 0;
                    rise = (e_qtr == 3);
                    fall = (e_qtr == 1);
                    e_qtr = (e_qtr + 1) % 4;
                end else e_tck++;
            end
            if (rise) begin
                if (e_row >= rows_tab[duty_sel] - 1) begin e_row = 0; wrap = 1; end
                else e_row++;
                e_frm = wrap;
                if (wrap) e_alt ^= 1;
            end
            sh  = shift_on_rise ? rise : fall;
            inj = shift_on_rise ? wrap : (fall && old_frm);
            if (sh) begin
                if (inj) begin toks = {}; toks.push_back(0); end
                else advance_toks();
            end
        end else begin
            e_tck = 0; e_qtr = 0; e_row = 127; e_frm = 0; e_alt = ext_alt;
            edg = shift_on_rise ? (ext_shift_clk && e_clq == 0) : (!ext_shift_clk && e_clq == 1);
            if (edg) begin
                advance_toks();
                if (scan_up ? end1_in : end2_in) toks.push_front(0);
            end
        end
        e_clq = ext_shift_clk;
    endtask

    task automatic compare();
        logic [N-1:0] ecom;
        bit far, near;
        string tc, tt;
        ecom = '0;
        far = 0;
        foreach (toks[i]) begin
            ecom[scan_up ? toks[i] : N - 1 - toks[i]] = 1'b1;
            if (toks[i] == N - 1) far = 1;
        end
        near = master_mode && e_frm != 0;
        tc = rst ? "R11" : (master_mode ? "R6 R7" : "R9");
        tt = rst ? "R11" : (master_mode ? "R3" : "R10");
        chk(tc, "com_sel", 64'(com_sel), 64'(ecom));
        chk(tt, "row_clk", 64'(row_clk), master_mode ? 64'(e_qtr < 2) : 64'(e_clq));
        chk(tt, "col_clk_a", 64'(col_clk_a), 64'(master_mode && e_qtr != 0));
        chk(tt, "col_clk_b", 64'(col_clk_b), 64'(master_mode && e_qtr != 1));
        chk(master_mode ? "R4" : "R10", "frame_mark", 64'(frame_mark), 64'(e_frm));
        chk(master_mode ? "R5" : "R10", "alt_pol", 64'(alt_pol), 64'(e_alt));
        tc = master_mode ? "R8" : "R9";
        chk(tc, "end1_out", 64'(end1_out), 64'(scan_up ? near : far));
        chk(tc, "end2_out", 64'(end2_out), 64'(scan_up ? far : near));
        chk(tc, "end1_oe", 64'(end1_oe), 64'(scan_up ? master_mode : 1'b1));
        chk(tc, "end2_oe", 64'(end2_oe), 64'(scan_up ? 1'b1 : master_mode));
        if (master_mode && !rst) begin
            int qcyc;
            qcyc = (freq_sel ? QT : QT / 2) * tick_div;
            if (frame_mark && !prev_frm) begin
                if (last_frm_rise >= 0)
                    chk("R1", "frame period", 64'(cyc - last_frm_rise), 64'(rows_tab[duty_sel] * 4 * qcyc));
                last_frm_rise = cyc;
            end
            if (row_clk && !prev_cl) last_cl_rise = cyc;
            if (!row_clk && prev_cl && last_cl_rise >= 0)
                chk("R2", "row_clk high length", 64'(cyc - last_cl_rise), 64'(2 * qcyc));
        end
        prev_frm = frame_mark;
        prev_cl  = row_clk;
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        cyc++;
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        osc_tick = 1'b0;
        repeat (2) step();
        rst = 1'b0;
        last_frm_rise = -1;
        last_cl_rise  = -1;
    endtask

    task automatic run_master(input logic [1:0] ds, input logic fs, input logic up,
                              input logic onr, input int div, input int ncyc);
        master_mode = 1'b1; duty_sel = ds; freq_sel = fs; scan_up = up;
        shift_on_rise = onr; tick_div = div;
        ext_shift_clk = 1'b0; ext_alt = 1'b0; end1_in = 1'b0; end2_in = 1'b0;
        do_reset();
        for (int i = 0; i < ncyc; i++) begin
            osc_tick = (i % div) == 0;
            step();
        end
    endtask

    task automatic run_slave(input logic up, input logic onr, input int ncyc);
        int lf;
        master_mode = 1'b0; duty_sel = 2'd1; freq_sel = 1'b1; scan_up = up;
        shift_on_rise = onr; tick_div = 1;
        ext_shift_clk = 1'b0; ext_alt = 1'b0; end1_in = 1'b0; end2_in = 1'b0;
        do_reset();
        lf = 32'h5a3c;
        for (int i = 0; i < ncyc; i++) begin
            osc_tick = 1'b1;
            if (i % 3 == 0) ext_shift_clk = ~ext_shift_clk;
            if (i % 50 == 0) ext_alt = ~ext_alt;
            lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
            end1_in = lf[0];
            end2_in = lf[3];
            step();
        end
    endtask

    initial begin
        prev_frm = 1'b0; prev_cl = 1'b0;
        master_mode = 1'b1; duty_sel = 2'd0; freq_sel = 1'b1; scan_up = 1'b1;
        shift_on_rise = 1'b1; ext_shift_clk = 1'b0; ext_alt = 1'b0;
        end1_in = 1'b0; end2_in = 1'b0;
        model_reset();
        do_reset();
        // R11: explicit reset state
        chk("R11", "reset com_sel", 64'(com_sel), 64'd0);
        chk("R11", "reset frame_mark", 64'(frame_mark), 64'd0);
        chk("R11", "reset alt_pol", 64'(alt_pol), 64'd0);
        chk("R11", "reset row_clk", 64'(row_clk), 64'd1);
        run_master(2'd0, 1'b1, 1'b1, 1'b1, 1, 1000);
        run_master(2'd1, 1'b0, 1'b0, 1'b0, 1, 700);
        run_master(2'd2, 1'b1, 1'b1, 1'b0, 2, 3300);
        run_master(2'd3, 1'b1, 1'b0, 1'b1, 1, 2200);
        run_master(2'd0, 1'b0, 1'b0, 1'b1, 3, 1300);
        run_slave(1'b1, 1'b1, 600);
        run_slave(1'b0, 1'b0, 600);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule